// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Slave

This block is a two-wire serial slave that lets a bus controller read and write a small bank of byte-wide configuration registers, such as per-output enable bits. The serial clock and data line are sampled by a faster system clock. Start and stop conditions are recovered from the samples. The data line is driven only by pulling it low through an open-drain enable. Every register reloads its default value at reset, so the device works with no serial traffic at all.

After the address byte, the controller sends a command byte. This byte chooses between single-byte access at a given offset and block access that starts at register 0. It also carries a select field that must be zero. A block write sends a byte count before its data. A block read returns the register count and then the registers in ascending order. All bytes travel most significant bit first.

Top module: `smbus_regfile`

## Requirements
- R1: While reset is asserted and right after it is released, the register outputs equal the INIT parameter, with register k at bits 8k+7:8k. The data line is not driven.
- R2: The slave acknowledges an address byte only when its upper seven bits are 69h, which gives D2h to write and D3h to read. After any other address it acknowledges nothing until the next start.
- R3: A command byte with bit 7 set selects single-byte mode, and bits 4:0 give the offset. The first data byte that follows is stored at that offset and acknowledged. Any further data byte in the same transfer is not acknowledged and is dropped.
- R4: A single-byte read is address D2h, command, repeated start, address D3h. It returns the register at the offset, and each byte the controller acknowledges is followed by the next offset. An offset at or above NREGS reads as 00h, and writes to such an offset are acknowledged but change nothing.
- R5: A command byte whose bits 6:5 are not 00 is not acknowledged and changes no register.
- R6: A command byte with bit 7 clear selects block mode. The next byte is a count, and the data bytes after it are written to registers 0, 1, 2 and on in order. A data byte is acknowledged and stored only while both the count and the register bank are not yet used up. Any other data byte is not acknowledged, and the transfer ends.
- R7: A block read returns NREGS as its first byte, then registers 0 up to NREGS-1 in order, and 00h after the last register.
- R8: A data byte is stored only when the slave acknowledges it, and registers change only while the serial clock is low. A byte cut short by a stop or start changes nothing, and bytes completed before it stay stored.
- R9: When the controller does not acknowledge a read byte, the slave stops driving the data line until the next start.
- R10: The slave changes its drive on the data line only while the serial clock is low. It releases the line on every start and every stop.
- R11: A read address D3h is not acknowledged unless a command byte was accepted earlier in the same transfer, that is, since the last stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_drv_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| regs_o | output | NREGS*8 | Register contents, register k at bits 8k+7:8k |

## Verification
The assertions assume that the controller changes the data line only while the serial clock is low, except when it makes a start or a stop. They also assume that every level of both lines lasts several system clocks, so that the two-stage synchronizer never sees the two lines move in the same sample. The bench master enforces this by holding each clock phase for ten system clocks and moving data halfway through the low phase. The bench also never begins a start or a stop while the slave could still be pulling the line low.

// File: rtl/smbus_regfile.sv
module smbus_regfile #(
  parameter int              NREGS    = 8,
  parameter logic [6:0]      DEV_ADDR = 7'h69,
  parameter logic [NREGS*8-1:0] INIT  = 64'h0F1E2D3C4B5A6978
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drv_low,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int PW = 6;
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [PW-1:0] NR = PW'(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s, rise, fall, start_ev, stop_ev;
  st_t        st;
  logic [7:0] sh, left;
  logic [6:0] txb;
  logic [3:0] bitcnt;
  logic [PW-1:0] ptr;
  logic       cmd_ok, bytemode, cnt_sent, wr_done, ack;
  logic [7:0] rd_val;
  logic [7:0] mem [NREGS];

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign rise     = scl_s & ~scl_p;
  assign fall     = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;             sda_p <= sda_s;
    end

  always_comb begin
    if (!bytemode && !cnt_sent) rd_val = 8'(NREGS);
    else if (ptr < NR)          rd_val = mem[ptr[IW-1:0]];
    else                        rd_val = 8'h00;
  end

  always_comb begin
    case (st)
      S_ADDR:  ack = (sh[7:1] == DEV_ADDR) && (!sh[0] || cmd_ok);
      S_CMD:   ack = (sh[6:5] == 2'b00);
      S_CNT:   ack = 1'b1;
      S_WR:    ack = bytemode ? !wr_done : ((left != 8'd0) && (ptr < NR));
      default: ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; left <= '0; txb <= '0; bitcnt <= '0; ptr <= '0;
      cmd_ok <= 1'b0; bytemode <= 1'b0; cnt_sent <= 1'b0; wr_done <= 1'b0;
      sda_drv_low <= 1'b0;
      for (int i = 0; i < NREGS; i++) mem[i] <= INIT[i*8 +: 8];
    end else if (start_ev) begin
      st <= S_ADDR; bitcnt <= '0; sda_drv_low <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; cmd_ok <= 1'b0; sda_drv_low <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (bitcnt < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd9 && st == S_RD && sda_s) begin
          st <= S_IDLE; cmd_ok <= 1'b0;
        end
      end else if (fall) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (st == S_RD) sda_drv_low <= 1'b0;
          else if (!ack) begin
            sda_drv_low <= 1'b0; st <= S_IDLE; cmd_ok <= 1'b0;
          end else begin
            sda_drv_low <= 1'b1;
            case (st)
              S_ADDR: st <= sh[0] ? S_RD : S_CMD;
              S_CMD: begin
                cmd_ok <= 1'b1; bytemode <= sh[7]; cnt_sent <= 1'b0; wr_done <= 1'b0;
                ptr <= sh[7] ? {1'b0, sh[4:0]} : '0;
                st  <= sh[7] ? S_WR : S_CNT;
              end
              S_CNT: begin left <= sh; st <= S_WR; end
              S_WR: begin
                if (ptr < NR) begin
                  mem[ptr[IW-1:0]] <= sh;
                  ptr <= ptr + 1'b1;
                end
                if (bytemode) wr_done <= 1'b1;
                else          left <= left - 8'd1;
              end
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == S_RD) begin
            txb <= rd_val[6:0];
            sda_drv_low <= ~rd_val[7];
            if (!bytemode && !cnt_sent) cnt_sent <= 1'b1;
            else if (ptr < NR)          ptr <= ptr + 1'b1;
          end else sda_drv_low <= 1'b0;
        end else if (st == S_RD) begin
          sda_drv_low <= ~txb[6];
          txb <= {txb[5:0], 1'b0};
        end
      end
    end

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem[g];
  end
endmodule

module smbus_regfile_chk #(
  parameter int              NREGS = 8,
  parameter logic [NREGS*8-1:0] INIT = 64'h0F1E2D3C4B5A6978
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               start_ev,
  input logic               stop_ev,
  input logic               sda_drv_low,
  input logic [NREGS*8-1:0] regs_o
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> regs_o == INIT); // R1
  AST_REGS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_s); // R8
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv_low) |-> !scl_s); // R10
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_drv_low); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_drv_low); // R10
endmodule

bind smbus_regfile smbus_regfile_chk #(.NREGS(NREGS), .INIT(INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_drv_low(sda_drv_low), .regs_o(regs_o));

// File: tb/sim_smbus_regfile.sv
`timescale 1ns/1ps
module sim_smbus_regfile;
  localparam int NREGS = 8;
  localparam logic [NREGS*8-1:0] INIT = 64'h0F1E2D3C4B5A6978;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_bus, sda_drv_low;
  logic [NREGS*8-1:0] regs_o;
  logic [7:0] model [NREGS];
  int nchk = 0, nfail = 0;

  assign sda_bus = m_sda & ~sda_drv_low;
  always #2.5 clk = ~clk;

  smbus_regfile #(.NREGS(NREGS), .INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_drv_low(sda_drv_low), .regs_o(regs_o));

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NREGS*8-1:0] flat();
    logic [NREGS*8-1:0] f;
    for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic bit exp_wack(input int i, input int n);
    return (i < n) && (i < NREGS);
  endfunction

  function automatic logic [7:0] exp_blk(input int i);
    if (i == 0) return 8'(NREGS);
    if (i <= NREGS) return model[i-1];
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_off(input int off);
    return (off < NREGS) ? model[off] : 8'h00;
  endfunction

  task automatic bstart();
    scl = 1'b0; waitc(5); m_sda = 1'b1; waitc(5);
    scl = 1'b1; waitc(5); m_sda = 1'b0; waitc(5); scl = 1'b0;
  endtask

  task automatic bstop();
    waitc(5); m_sda = 1'b0; waitc(5); scl = 1'b1; waitc(5); m_sda = 1'b1; waitc(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      waitc(5); m_sda = b[7-i]; waitc(5); scl = 1'b1; waitc(10); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    waitc(5); m_sda = 1'b1; waitc(5); scl = 1'b1; waitc(5);
    ack = !sda_bus; waitc(5); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitc(10); scl = 1'b1; waitc(5); b[7-i] = sda_bus; waitc(5); scl = 1'b0;
    end
    waitc(5); m_sda = !mack; waitc(5); scl = 1'b1; waitc(10); scl = 1'b0;
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    bit a;
    bstart();
    send_byte(8'hD2, a); chk("R2 addr ack", a, 1);
    send_byte({3'b100, off[4:0]}, a); chk("R3 cmd ack", a, 1);
    send_byte(d, a); chk("R3 data ack", a, 1);
    bstop();
    if (off < NREGS) model[off] = d;
    chk("R3 regs after byte write", regs_o, flat());
    chk("R10 released after stop", sda_drv_low, 0);
  endtask

  task automatic byte_read(input int off, input int n);
    bit a; logic [7:0] d;
    bstart();
    send_byte(8'hD2, a); chk("R4 addr ack", a, 1);
    send_byte({3'b100, off[4:0]}, a); chk("R4 cmd ack", a, 1);
    bstart();
    send_byte(8'hD3, a); chk("R4 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n-1);
      chk("R4 byte read data", d, exp_off(off + i));
    end
    bstop();
  endtask

  task automatic block_write(input int cnt, input int nsend, input int cut_bits);
    bit a; logic [7:0] d;
    bstart();
    send_byte(8'hD2, a); chk("R6 addr ack", a, 1);
    send_byte(8'h00, a); chk("R6 cmd ack", a, 1);
    send_byte(8'(cnt), a); chk("R6 count ack", a, 1);
    for (int i = 0; i < nsend; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      chk("R6 block data ack", a, exp_wack(i, cnt));
      if (a && exp_wack(i, cnt)) model[i] = d;
      if (!a) break;
    end
    if (cut_bits > 0) send_bits(8'($urandom), cut_bits);
    bstop();
    chk(cut_bits > 0 ? "R8 regs after cut block write" : "R6 regs after block write",
        regs_o, flat());
  endtask

  task automatic block_read(input int n);
    bit a; logic [7:0] d;
    bstart();
    send_byte(8'hD2, a); chk("R7 addr ack", a, 1);
    send_byte(8'h00, a); chk("R7 cmd ack", a, 1);
    bstart();
    send_byte(8'hD3, a); chk("R7 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n-1);
      chk("R7 block read data", d, exp_blk(i));
    end
    bstop();
  endtask

  initial begin
    bit a; logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREGS; i++) model[i] = INIT[i*8 +: 8];
    waitc(3);
    chk("R1 regs during reset", regs_o, INIT);
    chk("R1 no drive during reset", sda_drv_low, 0);
    rst_n = 1'b1; waitc(5);
    chk("R1 regs after reset", regs_o, INIT);

    byte_write(3, 8'h5A);
    byte_read(3, 1);
    byte_read(6, 3);

    bstart();
    send_byte(8'hD2, a); send_byte(8'h82, a);
    send_byte(8'hC4, a); chk("R3 first data ack", a, 1);
    send_byte(8'h99, a); chk("R3 second data nack", a, 0);
    bstop(); model[2] = 8'hC4;
    chk("R3 second byte dropped", regs_o, flat());

    byte_write(20, 8'h77);
    byte_read(20, 1);

    bstart();
    send_byte(8'hA4, a); chk("R2 wrong addr nack", a, 0);
    send_byte(8'h81, a); chk("R2 idle after mismatch", a, 0);
    send_byte(8'h11, a); chk("R2 idle data nack", a, 0);
    bstop();
    chk("R2 regs unchanged", regs_o, flat());

    bstart();
    send_byte(8'hD2, a);
    send_byte(8'hA1, a); chk("R5 select field nack", a, 0);
    send_byte(8'h33, a); chk("R5 data after bad cmd nack", a, 0);
    bstop();
    chk("R5 regs unchanged", regs_o, flat());

    bstart();
    send_byte(8'hD3, a); chk("R11 read without command nack", a, 0);
    bstop();

    block_write(3, 3, 0);
    block_write(2, 3, 0);
    block_write(10, 9, 0);
    block_read(NREGS + 2);

    block_write(4, 2, 5);
    bstart();
    send_byte(8'hD2, a); send_byte(8'h85, a);
    send_bits(8'hEE, 4);
    bstop();
    chk("R8 cut byte write dropped", regs_o, flat());

    bstart();
    send_byte(8'hD2, a); send_byte(8'h81, a);
    bstart(); send_byte(8'hD3, a);
    recv_byte(d, 0); chk("R4 read before nack", d, model[1]);
    recv_byte(d, 0); chk("R9 released after nack", d, 8'hFF);
    bstop();

    for (int it = 0; it < 25; it++) begin
      case ($urandom % 4)
        0: byte_write($urandom % NREGS, 8'($urandom));
        1: byte_read($urandom % NREGS, 1 + $urandom % 2);
        2: block_write(1 + $urandom % NREGS, 1 + $urandom % NREGS, 0);
        default: block_read(1 + $urandom % (NREGS + 1));
      endcase
    end
    block_read(NREGS + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule